// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block carries out the memory phase of a 16-bit processor's data-movement instructions. When the pipeline starts an operation, the block samples the instruction word, the incremented program counter, the base-register value and the store value. It then forms the effective address and drives one or two word accesses on a single-port memory. For loads it returns the word that was read, together with the destination register index and condition flags, so the register file can write it back.

There are three addressing styles. PC-relative forms add a sign-extended 9-bit offset to the incremented PC. Base forms add a sign-extended 6-bit offset to a base register value. Indirect forms first read a pointer word at the PC-relative address and then make the real access at the address held in that pointer. The address-only form never touches memory and returns the computed address as its result.

The memory side uses a request/ready handshake. A read returns its data one cycle after the cycle in which the handshake completes. A one-cycle `done` pulse marks the end of each operation.

Top module: `lsq_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `mem_req`, `done`, `reg_we` and `flags_we` are all 0.
- R2: Only opcode field `instr[15:12]` values 0010 (PC load), 0110 (base load), 1010 (indirect load), 1110 (address-only), 0011 (PC store), 0111 (base store) and 1011 (indirect store) are accepted. A `start` carrying any other opcode is ignored: `busy` stays 0 and no request or `done` follows.
- R3: PC-relative forms (0010, 0011, 1010, 1011, 1110) use effective address `pc_next + sext(instr[8:0])`. Base forms (0110, 0111) use `base_val + sext(instr[5:0])`, with modulo-2^16 wrap. `pc_next`, `base_val`, `src_val` and `instr` are sampled only in the cycle where `start` is accepted.
- R4: A PC or base load makes exactly one read, at the effective address. The word read is returned on `reg_wdata` with `reg_waddr = instr[11:9]`.
- R5: A PC or base store makes exactly one access: a whole-word write of `src_val` at the effective address. No register write and no flag update take place.
- R6: An indirect load reads the pointer word at the effective address, then reads the word at the pointer's value, and returns that second word.
- R7: An indirect store reads the pointer word at the effective address, then writes `src_val` to the pointer's value. The pointer read never has `mem_we` set.
- R8: The address-only form makes no memory request and returns the effective address on `reg_wdata`.
- R9: In the `done` cycle of a load or the address-only form, `reg_we` and `flags_we` are 1. `nzp` is 100 if the result's bit 15 is set, 010 if the result is zero, and 001 otherwise.
- R10: While `mem_req` is high and `mem_ready` is low, the request, address, write enable and write data hold steady. Read data is taken from `mem_rdata` one cycle after the handshake cycle.
- R11: Let s be the number of cycles each request waits for `mem_ready`. Counted in clock edges after the edge that accepts `start`, `done` is high after edge 1 for address-only, after edge 2+s for stores, 3+s for loads, 4+2s for indirect stores and 5+2s for indirect loads.
- R12: `busy` is high from the edge after acceptance through the `done` cycle. `done` lasts exactly one cycle. A `start` raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| instr | input | 16 | Instruction word |
| pc_next | input | DATA_W | Incremented program counter |
| base_val | input | DATA_W | Base register value for base forms |
| src_val | input | DATA_W | Value to store |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | DATA_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read handshake |
| done | output | 1 | One-cycle completion pulse |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 3 | Destination register index |
| reg_wdata | output | DATA_W | Value to write back |
| flags_we | output | 1 | Condition flag update strobe |
| nzp | output | 3 | Negative/zero/positive flags of the result |

## Verification
A wrong state or a lost wait phase changes how many edges pass between acceptance and `done`, so the bench measures that count exactly for every opcode and stall length. A wrongly latched pointer or address becomes visible at the next request, one or two cycles later, as a wrong `mem_addr`, and then as a wrong `reg_wdata` in the `done` cycle. A wrong sign extension or a wrong choice of adder operand appears as a wrong first request address, or as a wrong returned value for the address-only form.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   localparam int REG_IDX_W = 3;
   localparam int OPC_W     = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_LD  = 4'b0010,
      OP_ST  = 4'b0011,
      OP_LDR = 4'b0110,
      OP_STR = 4'b0111,
      OP_LDI = 4'b1010,
      OP_STI = 4'b1011,
      OP_LEA = 4'b1110
   } opc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_IND,
      ST_ACCESS,
      ST_DONE
   } seq_state_e;

   typedef struct packed {
      logic                 valid;
      logic                 is_store;
      logic                 is_ind;
      logic                 is_lea;
      logic                 use_base;
      logic [REG_IDX_W-1:0] dreg;
   } dec_t;

endpackage

// File: rtl/lsq_decode.sv
module lsq_decode
   import lsq_pkg::*;
(
   input  logic [OPC_W-1:0]     opcode,
   input  logic [REG_IDX_W-1:0] dr_field,
   output dec_t                 dec
);

   always_comb begin
      dec      = '0;
      dec.dreg = dr_field;
      case (opcode)
         OP_LD:  dec.valid = 1'b1;
         OP_ST:  begin dec.valid = 1'b1; dec.is_store = 1'b1; end
         OP_LDR: begin dec.valid = 1'b1; dec.use_base = 1'b1; end
         OP_STR: begin dec.valid = 1'b1; dec.use_base = 1'b1; dec.is_store = 1'b1; end
         OP_LDI: begin dec.valid = 1'b1; dec.is_ind = 1'b1; end
         OP_STI: begin dec.valid = 1'b1; dec.is_ind = 1'b1; dec.is_store = 1'b1; end
         OP_LEA: begin dec.valid = 1'b1; dec.is_lea = 1'b1; end
         default: dec.valid = 1'b0;
      endcase
   end

endmodule

// File: rtl/lsq_agen.sv
module lsq_agen #(
   parameter int DATA_W       = 16,
   parameter int PC_OFF_W     = 9,
   parameter int BASE_OFF_W   = 6,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [PC_OFF_W-1:0] off_field,
   input  logic                use_base,
   input  logic [DATA_W-1:0]   pc_val,
   input  logic [DATA_W-1:0]   base_val,
   output logic [DATA_W-1:0]   ea
);

   localparam int PC_EXT_W   = DATA_W - PC_OFF_W;
   localparam int BASE_EXT_W = DATA_W - BASE_OFF_W;

   if (PC_OFF_W >= DATA_W || BASE_OFF_W >= PC_OFF_W) begin : g_bad_widths
      $error("lsq_agen: offset widths must satisfy BASE_OFF_W < PC_OFF_W < DATA_W");
   end

   logic [DATA_W-1:0] pc_off_x;
   logic [DATA_W-1:0] base_off_x;

   assign pc_off_x   = {{PC_EXT_W{off_field[PC_OFF_W-1]}}, off_field};
   assign base_off_x = {{BASE_EXT_W{off_field[BASE_OFF_W-1]}}, off_field[BASE_OFF_W-1:0]};

   if (SHARED_ADDER) begin : g_shared
      logic [DATA_W-1:0] op_a;
      logic [DATA_W-1:0] op_b;
      assign op_a = use_base ? base_val   : pc_val;
      assign op_b = use_base ? base_off_x : pc_off_x;
      assign ea   = op_a + op_b;
   end else begin : g_dual
      logic [DATA_W-1:0] sum_pc;
      logic [DATA_W-1:0] sum_base;
      assign sum_pc   = pc_val + pc_off_x;
      assign sum_base = base_val + base_off_x;
      assign ea       = use_base ? sum_base : sum_pc;
   end

endmodule

// File: rtl/lsq_nzp.sv
module lsq_nzp #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] value,
   output logic [2:0]        nzp
);

   logic is_neg;
   logic is_zero;

   assign is_neg  = value[DATA_W-1];
   assign is_zero = (value == '0);
   assign nzp     = {is_neg, is_zero, !is_neg && !is_zero};

endmodule

// File: rtl/lsq_seq.sv
module lsq_seq
   import lsq_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] pc_next,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] src_val,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              reg_we,
   output logic [2:0]        reg_waddr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              flags_we,
   output logic [2:0]        nzp
);

   localparam int INSTR_W    = 16;
   localparam int PC_OFF_W   = 9;
   localparam int BASE_OFF_W = 6;
   localparam int OPC_LSB    = INSTR_W - OPC_W;
   localparam int DR_LSB     = OPC_LSB - REG_IDX_W;

   if (DATA_W != INSTR_W) begin : g_bad_data_w
      $error("lsq_seq: a pointer word must be a full address, DATA_W must be 16");
   end

   seq_state_e            state_q;
   dec_t                  dec_in;
   dec_t                  dec_q;
   logic [PC_OFF_W-1:0]   off_q;
   logic [DATA_W-1:0]     pc_q;
   logic [DATA_W-1:0]     base_q;
   logic [DATA_W-1:0]     src_q;
   logic [DATA_W-1:0]     addr_q;
   logic [DATA_W-1:0]     data_q;
   logic                  wait_q;
   logic [DATA_W-1:0]     ea;

   lsq_decode u_decode (
      .opcode   (instr[INSTR_W-1:OPC_LSB]),
      .dr_field (instr[OPC_LSB-1:DR_LSB]),
      .dec      (dec_in)
   );

   lsq_agen #(
      .DATA_W       (DATA_W),
      .PC_OFF_W     (PC_OFF_W),
      .BASE_OFF_W   (BASE_OFF_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_agen (
      .off_field (off_q),
      .use_base  (dec_q.use_base),
      .pc_val    (pc_q),
      .base_val  (base_q),
      .ea        (ea)
   );

   lsq_nzp #(.DATA_W(DATA_W)) u_nzp (
      .value (data_q),
      .nzp   (nzp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dec_q   <= '0;
         off_q   <= '0;
         pc_q    <= '0;
         base_q  <= '0;
         src_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         wait_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start && dec_in.valid) begin
                  dec_q   <= dec_in;
                  off_q   <= instr[PC_OFF_W-1:0];
                  pc_q    <= pc_next;
                  base_q  <= base_val;
                  src_q   <= src_val;
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               addr_q <= ea;
               wait_q <= 1'b0;
               if (dec_q.is_lea) begin
                  data_q  <= ea;
                  state_q <= ST_DONE;
               end else if (dec_q.is_ind) begin
                  state_q <= ST_IND;
               end else begin
                  state_q <= ST_ACCESS;
               end
            end
            ST_IND: begin
               if (!wait_q) begin
                  if (mem_ready) wait_q <= 1'b1;
               end else begin
                  addr_q  <= mem_rdata;
                  wait_q  <= 1'b0;
                  state_q <= ST_ACCESS;
               end
            end
            ST_ACCESS: begin
               if (!wait_q) begin
                  if (mem_ready) begin
                     if (dec_q.is_store) state_q <= ST_DONE;
                     else                wait_q  <= 1'b1;
                  end
               end else begin
                  data_q  <= mem_rdata;
                  wait_q  <= 1'b0;
                  state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign mem_req   = ((state_q == ST_IND) || (state_q == ST_ACCESS)) && !wait_q;
   assign mem_we    = mem_req && (state_q == ST_ACCESS) && dec_q.is_store;
   assign mem_addr  = addr_q;
   assign mem_wdata = src_q;
   assign done      = (state_q == ST_DONE);
   assign reg_we    = done && !dec_q.is_store;
   assign flags_we  = reg_we;
   assign reg_waddr = dec_q.dreg;
   assign reg_wdata = data_q;

endmodule

// File: rtl/lsq_seq_chk.sv
module lsq_seq_chk
   import lsq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              reg_we,
   input logic              flags_we,
   input logic [2:0]        nzp,
   input seq_state_e        state,
   input logic              is_lea,
   input logic              is_store
);

   // R1: an idle block drives no request, completion or writeback
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !done && !reg_we && !flags_we));

   // R5: stores never write back
   assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_store) |-> (!reg_we && !flags_we));

   // R5: a write is always part of a store request
   assert_we_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_req && is_store));

   // R7: the pointer fetch is a read
   assert_ptr_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IND) && mem_req) |-> !mem_we);

   // R8: address-only form never touches memory
   assert_lea_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && is_lea) |-> !mem_req);

   // R9: flags update with the register write and are one-hot
   assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flags_we |-> (reg_we && ($countones(nzp) == 1)));

   // R10: a stalled request holds
   assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R12: completion lasts one cycle
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind lsq_seq lsq_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .reg_we    (reg_we),
   .flags_we  (flags_we),
   .nzp       (nzp),
   .state     (state_q),
   .is_lea    (dec_q.is_lea),
   .is_store  (dec_q.is_store)
);

// File: tb/lsq_seq_tb.sv
module lsq_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] pc_next = '0;
   logic [15:0] base_val = '0;
   logic [15:0] src_val = '0;
   logic        busy, mem_req, mem_we, done, reg_we, flags_we;
   logic [15:0] mem_addr, mem_wdata, reg_wdata;
   logic        mem_ready;
   logic [15:0] mem_rdata;
   logic [2:0]  reg_waddr, nzp;

   int n_tests = 0;
   int n_fail  = 0;
   int stall   = 0;
   int n_rd    = 0;
   int n_wr    = 0;
   logic [15:0] rd_a [2];
   logic [15:0] wr_a, wr_d;
   logic [15:0] mem [256];

   always #5 clk = ~clk;

   lsq_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .pc_next(pc_next), .base_val(base_val), .src_val(src_val),
      .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .done(done), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .flags_we(flags_we), .nzp(nzp)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   function automatic logic [2:0] flags_of(input logic [15:0] v);
      if (v[15])         return 3'b100;
      else if (v == '0)  return 3'b010;
      else               return 3'b001;
   endfunction

   // memory responder: ready after 'stall' waiting cycles, data one cycle after the handshake
   initial begin : responder
      logic        pend, pend_we;
      logic [15:0] pend_a, pend_d;
      int          cnt;
      pend = 1'b0; pend_we = 1'b0; pend_a = '0; pend_d = '0; cnt = 0;
      mem_ready = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (pend) begin
            if (pend_we) begin
               mem[pend_a[7:0]] = pend_d;
               wr_a = pend_a; wr_d = pend_d; n_wr++;
            end else begin
               mem_rdata = mem[pend_a[7:0]];
               if (n_rd < 2) rd_a[n_rd] = pend_a;
               n_rd++;
            end
            pend = 1'b0;
         end
         if (mem_req && rst_n) begin
            if (cnt >= stall) begin
               mem_ready = 1'b1; cnt = 0; pend = 1'b1;
               pend_we = mem_we; pend_a = mem_addr; pend_d = mem_wdata;
            end else begin
               mem_ready = 1'b0; cnt++;
            end
         end else begin
            mem_ready = 1'b0; cnt = 0;
         end
      end
   end

   task automatic run_op(input logic [3:0] opc, input logic [8:0] off, input logic [2:0] dr,
                         input logic [15:0] pcv, input logic [15:0] bv, input logic [15:0] sv);
      bit is_store, is_ind, is_lea, use_base, valid;
      logic [15:0] ea, ptr, fin, val;
      int exp_lat, c;
      valid    = (opc == 4'b0010) || (opc == 4'b0110) || (opc == 4'b1010) || (opc == 4'b1110) ||
                 (opc == 4'b0011) || (opc == 4'b0111) || (opc == 4'b1011);
      is_store = valid && opc[0];
      is_ind   = (opc == 4'b1010) || (opc == 4'b1011);
      is_lea   = (opc == 4'b1110);
      use_base = (opc == 4'b0110) || (opc == 4'b0111);
      ea  = use_base ? bv + {{10{off[5]}}, off[5:0]} : pcv + {{7{off[8]}}, off};
      ptr = mem[ea[7:0]];
      fin = is_ind ? ptr : ea;
      val = is_lea ? ea : mem[fin[7:0]];
      exp_lat = is_lea ? 1 : is_ind ? (is_store ? 4 + 2*stall : 5 + 2*stall)
                                    : (is_store ? 2 + stall : 3 + stall);
      n_rd = 0; n_wr = 0;
      instr = {opc, dr, off}; pc_next = pcv; base_val = bv; src_val = sv; start = 1'b1;
      tick();
      start = 1'b0; pc_next = 16'hDEAD; base_val = 16'hBEEF; src_val = 16'h0BAD;
      if (!valid) begin
         for (int i = 0; i < 6; i++) begin
            chk("R2 ignored opcode busy", busy, 0);
            chk("R2 ignored opcode req/done", {mem_req, done}, 0);
            tick();
         end
         chk("R2 ignored opcode accesses", n_rd + n_wr, 0);
         return;
      end
      chk("R12 busy after accept", busy, 1);
      c = 1;
      while (!done && c < 60) begin
         if (c == 2) begin
            // R12: a second start while busy must be ignored
            instr = {4'b0011, 3'd0, 9'h001}; start = 1'b1;
         end
         tick();
         start = 1'b0;
         c++;
      end
      chk("R11 latency", c - 1, exp_lat);
      chk("R9 reg_we", reg_we, !is_store);
      chk("R9 flags_we", flags_we, !is_store);
      if (is_store) begin
         chk("R5/R7 write count", n_wr, 1);
         chk("R5/R7 write address", wr_a, fin);
         chk("R5/R7 write data", wr_d, sv);
         chk("R7 read count", n_rd, is_ind ? 1 : 0);
      end else begin
         chk("R4/R6/R8 data", reg_wdata, val);
         chk("R4 dest reg", reg_waddr, dr);
         chk("R9 nzp", nzp, flags_of(val));
         chk("R8/R4/R6 read count", n_rd, is_lea ? 0 : (is_ind ? 2 : 1));
         chk("R4/R6 no write", n_wr, 0);
         if (is_ind) chk("R6 second read address", rd_a[1], ptr);
      end
      if (!is_lea) chk("R3 first address", rd_a[0] & {16{n_rd > 0}} | wr_a & {16{n_rd == 0}}, ea);
      tick();
      chk("R12 done one cycle", done, 0);
      chk("R1 idle again", {busy, mem_req}, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [8:0] offs [4];
      offs[0] = 9'h002; offs[1] = 9'h1FD; offs[2] = 9'h0FF; offs[3] = 9'h120;
      for (int i = 0; i < 256; i++)
         mem[i] = (i % 7 == 0) ? 16'h0000 : 16'(i * 16'h1357) ^ 16'(i << 9);
      repeat (3) tick();
      chk("R1 reset busy", busy, 0);
      chk("R1 reset outputs", {mem_req, done, reg_we, flags_we}, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 idle after reset", {busy, mem_req, done}, 0);
      // R3/R5: store at 0x3006 with offset 2 lands at 0x3009
      stall = 0;
      run_op(4'b0011, 9'h002, 3'd1, 16'h3007, 16'h0000, 16'h0005);
      for (int s = 0; s < 3; s++) begin
         stall = s;
         for (int op = 0; op < 16; op++) begin
            for (int o = 0; o < 4; o++) begin
               run_op(4'(op), offs[o], 3'(op + o), 16'h3000 + 16'(o * 97 + s),
                      16'hFFF0 + 16'(o * 5), 16'(o * 16'h4001 - s));
            end
         end
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule